// File: doc/BRIEF.md
# Synthesizer Serial Programming Sequencer

This block loads 24-bit control words into an external frequency synthesizer over a three-wire link: a serial clock, a serial data line and a latch strobe. It generates the serial clock by dividing the system clock. Data follows clock phase 0: data changes while the clock is low and holds steady through the rising edge. Each word goes out most significant bit first, as three back-to-back 8-bit bytes. The strobe stays low while the bytes shift. It pulses high only after the last bit, which commits the word inside the synthesizer.

A start pulse runs the mandatory power-up sequence of three words. The order is the reference-divider word, then the feedback-divider word, then the initialization word. The synthesizer output counts as valid only after all three. A ready flag reports when the sequence is complete. Once the block is idle, a host can request a single-word update at any time. While a transfer is under way, the block asserts busy and ignores all further requests. A chip-enable output goes high when the power-up sequence is accepted. The lock-detect input from the synthesizer passes through a two-flop synchronizer and appears as a lock status flag.

Top module: `synth_prog_seq`

## Requirements
- R1: During and after a synchronous reset, sclk, sdata, le, ce, busy, ready and lock_flag are all low.
- R2: A start accepted while idle raises ce at the accepting edge. It sends three words in this fixed order: ref_word, then fb_word, then init_word. ce then stays high.
- R3: Each word is 24 bits, sent MSB first. For every bit, the data is driven for HALF_DIV system clocks with sclk low, then sclk is high for HALF_DIV clocks. sdata never changes on a cycle where sclk rises.
- R4: le is low while bits shift. It rises on the cycle sclk falls after the 24th rising edge (HALF_DIV clocks after that edge). It stays high for LE_HOLD clocks, and sclk stays low throughout.
- R5: After le falls, the link stays quiet for 2*HALF_DIV clocks before the next word may begin. Inside the power-up sequence, the next word begins right after that gap.
- R6: The sclk half period is the larger of HALF_DIV and ceil(SYS_MHZ / (2*SCLK_MAX_MHZ)). With the defaults (250 MHz system clock), consecutive sclk rising edges are at least 50 ns apart.
- R7: busy rises at the edge that accepts a start or update request. It falls at the end of the quiet gap after the last word.
- R8: A start or update request seen while busy is high is ignored. No extra word is sent and the running sequence is not disturbed.
- R9: ready rises at the same edge busy falls after the third power-up word. A later accepted start clears it at the accepting edge. Single-word updates leave it unchanged.
- R10: An update request accepted while idle sends exactly one word, upd_word. If start and upd_req arrive in the same idle cycle, start wins and the update is dropped.
- R11: lock_flag equals lock_in delayed by two system clocks.
- R12: Whenever busy is low, sclk, sdata and le are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request the three-word power-up sequence |
| upd_req | input | 1 | Request a single-word update |
| ref_word | input | 24 | Reference-divider word, sent first |
| fb_word | input | 24 | Feedback-divider word, sent second |
| init_word | input | 24 | Initialization word, sent third |
| upd_word | input | 24 | Word for a single update |
| lock_in | input | 1 | Asynchronous lock-detect from the synthesizer |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data, MSB first |
| le | output | 1 | Latch strobe, pulses high after the third byte |
| ce | output | 1 | Synthesizer chip enable |
| busy | output | 1 | A transfer or its trailing gap is in progress |
| ready | output | 1 | The power-up sequence has completed |
| lock_flag | output | 1 | Synchronized lock status |

## Verification
The bench targets the hand-off between words inside the power-up sequence. A design that restarts one cycle early or late there shifts every following bit against the per-cycle model, or cuts the quiet gap measured from the strobe's fall. It reassembles every word at the strobe's rising edge. Bytes in the wrong order, an off-by-one bit count or a strobe raised before the last rising clock edge therefore shows up as a wrong word value. Requests arriving mid-transfer and a start coinciding with an update probe the acceptance logic. A design that lets either through sends an unexpected fourth word, or sends the update instead of the sequence. The ready flag is watched across a repeated start, which must clear it.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LOW,
    ENG_HIGH,
    ENG_LATCH,
    ENG_GAP
  } eng_state_t;
endpackage

// File: rtl/spg_serial_engine.sv
module spg_serial_engine #(
  parameter int HALF      = 7,
  parameter int LE_HOLD   = 2,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic              free,
  output logic              sclk,
  output logic              sdata,
  output logic              le
);
  import spg_pkg::*;

  localparam int CNT_W   = $clog2(2 * HALF + LE_HOLD + 1);
  localparam int BIT_W   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BYTE_CW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  eng_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [WORD_W-1:0]  shreg;
  logic [BIT_W-1:0]   bit_cnt;
  logic [BYTE_CW-1:0] byte_cnt;
  logic               half_end;
  logic               byte_end;
  logic               last_bit;

  assign half_end = (cnt == CNT_W'(HALF - 1));
  assign byte_end = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign last_bit = byte_end && (byte_cnt == BYTE_CW'(NUM_BYTES - 1));
  assign free     = (state == ENG_IDLE) ||
                    ((state == ENG_GAP) && (cnt == CNT_W'(2 * HALF - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      sclk     <= 1'b0;
      sdata    <= 1'b0;
      le       <= 1'b0;
    end else if (free && go) begin
      state    <= ENG_LOW;
      cnt      <= '0;
      shreg    <= word;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      sclk     <= 1'b0;
      sdata    <= word[WORD_W-1];
      le       <= 1'b0;
    end else begin
      case (state)
        ENG_LOW: begin
          if (half_end) begin
            sclk  <= 1'b1;
            cnt   <= '0;
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_HIGH: begin
          if (half_end) begin
            sclk <= 1'b0;
            cnt  <= '0;
            if (last_bit) begin
              sdata <= 1'b0;
              le    <= 1'b1;
              state <= ENG_LATCH;
            end else begin
              shreg <= shreg << 1;
              sdata <= shreg[WORD_W-2];
              state <= ENG_LOW;
              if (byte_end) begin
                bit_cnt  <= '0;
                byte_cnt <= byte_cnt + 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_LATCH: begin
          if (cnt == CNT_W'(LE_HOLD - 1)) begin
            le    <= 1'b0;
            cnt   <= '0;
            state <= ENG_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_GAP: begin
          if (free) begin
            cnt   <= '0;
            state <= ENG_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= ENG_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/spg_sequencer.sv
module spg_sequencer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              upd_req,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] fb_word,
  input  logic [WORD_W-1:0] init_word,
  input  logic [WORD_W-1:0] upd_word,
  input  logic              eng_free,
  output logic              eng_go,
  output logic [WORD_W-1:0] eng_word,
  output logic              busy,
  output logic              ready,
  output logic              ce
);
  localparam int PU_WORDS = 3;

  logic [WORD_W-1:0] pu_words [PU_WORDS];
  logic [1:0]        seq_idx;
  logic [1:0]        nxt_idx;
  logic              seq_on;
  logic              take_start;
  logic              take_upd;
  logic              word_done;
  logic              seq_next;

  assign pu_words[0] = ref_word;
  assign pu_words[1] = fb_word;
  assign pu_words[2] = init_word;

  always_comb begin
    nxt_idx    = seq_idx + 2'd1;
    take_start = start && !busy;
    take_upd   = upd_req && !busy && !start;
    word_done  = busy && eng_free;
    seq_next   = word_done && seq_on && (seq_idx != 2'(PU_WORDS - 1));
    eng_go     = take_start || take_upd || seq_next;
    if (take_start)     eng_word = pu_words[0];
    else if (seq_next)  eng_word = pu_words[nxt_idx];
    else                eng_word = upd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ready   <= 1'b0;
      ce      <= 1'b0;
      seq_on  <= 1'b0;
      seq_idx <= '0;
    end else if (take_start) begin
      ce      <= 1'b1;
      busy    <= 1'b1;
      ready   <= 1'b0;
      seq_on  <= 1'b1;
      seq_idx <= '0;
    end else if (take_upd) begin
      busy <= 1'b1;
    end else if (seq_next) begin
      seq_idx <= nxt_idx;
    end else if (word_done) begin
      busy <= 1'b0;
      if (seq_on) begin
        ready  <= 1'b1;
        seq_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spg_sync.sv
module spg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int SYS_MHZ      = 250,
  parameter int SCLK_MAX_MHZ = 20,
  parameter int HALF_DIV     = 7,
  parameter int LE_HOLD      = 2,
  parameter int BYTE_W       = 8,
  parameter int NUM_BYTES    = 3,
  parameter int SYNC_STAGES  = 2,
  localparam int WORD_W      = BYTE_W * NUM_BYTES,
  localparam int MIN_HALF    = (SYS_MHZ + 2 * SCLK_MAX_MHZ - 1) / (2 * SCLK_MAX_MHZ),
  localparam int EFF_HALF    = (HALF_DIV < MIN_HALF) ? MIN_HALF : HALF_DIV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              upd_req,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] fb_word,
  input  logic [WORD_W-1:0] init_word,
  input  logic [WORD_W-1:0] upd_word,
  input  logic              lock_in,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              ce,
  output logic              busy,
  output logic              ready,
  output logic              lock_flag
);
  logic              eng_free;
  logic              eng_go;
  logic [WORD_W-1:0] eng_word;

  spg_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .upd_req   (upd_req),
    .ref_word  (ref_word),
    .fb_word   (fb_word),
    .init_word (init_word),
    .upd_word  (upd_word),
    .eng_free  (eng_free),
    .eng_go    (eng_go),
    .eng_word  (eng_word),
    .busy      (busy),
    .ready     (ready),
    .ce        (ce)
  );

  spg_serial_engine #(
    .HALF      (EFF_HALF),
    .LE_HOLD   (LE_HOLD),
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_eng (
    .clk   (clk),
    .rst   (rst),
    .go    (eng_go),
    .word  (eng_word),
    .free  (eng_free),
    .sclk  (sclk),
    .sdata (sdata),
    .le    (le)
  );

  spg_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk  (clk),
    .rst  (rst),
    .din  (lock_in),
    .dout (lock_flag)
  );
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int HALF   = 7,
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic upd_req,
  input logic lock_in,
  input logic sclk,
  input logic sdata,
  input logic le,
  input logic ce,
  input logic busy,
  input logic ready,
  input logic lock_flag
);
  localparam int RUN_W = $clog2(HALF + 2);

  logic [RUN_W-1:0] hi_run;
  logic [1:0]       up_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      up_cnt <= '0;
    end else begin
      hi_run <= sclk ? hi_run + 1'b1 : '0;
      if (up_cnt != 2'd3) up_cnt <= up_cnt + 1'b1;
    end
  end

  assert_le_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
    le |-> !sclk);
  assert_le_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(le) |-> $fell(sclk));
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdata));
  assert_high_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_run == RUN_W'(HALF)));
  assert_idle_lines_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && !sdata && !le));
  assert_ce_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> ce);
  assert_ready_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $fell(busy));
  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start || upd_req));

  if (STAGES == 2) begin : g_lock
    assert_lock_latency_R11: assert property (@(posedge clk) disable iff (rst)
      (up_cnt == 2'd3) |-> (lock_flag == $past(lock_in, 2)));
  end
endmodule

bind synth_prog_seq spg_checker #(.HALF(EFF_HALF), .STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .upd_req   (upd_req),
  .lock_in   (lock_in),
  .sclk      (sclk),
  .sdata     (sdata),
  .le        (le),
  .ce        (ce),
  .busy      (busy),
  .ready     (ready),
  .lock_flag (lock_flag)
);

// File: tb/synth_prog_seq_test.sv
module synth_prog_seq_test;
  localparam int H     = 7;
  localparam int LH    = 2;
  localparam int W     = 24;
  localparam int CLKNS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, upd_req = 1'b0, lock_in = 1'b0;
  logic [W-1:0] ref_word = '0, fb_word = '0, init_word = '0, upd_word = '0;
  logic sclk, sdata, le, ce, busy, ready, lock_flag;

  int checks = 0;
  int errors = 0;

  always #(CLKNS / 2) clk = ~clk;

  synth_prog_seq uut (
    .clk(clk), .rst(rst), .start(start), .upd_req(upd_req),
    .ref_word(ref_word), .fb_word(fb_word), .init_word(init_word),
    .upd_word(upd_word), .lock_in(lock_in),
    .sclk(sclk), .sdata(sdata), .le(le), .ce(ce),
    .busy(busy), .ready(ready), .lock_flag(lock_flag)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0]   mq[$];          // per-cycle {sclk, sdata, le}
  logic [W-1:0] exp_words[$];
  int           exp_tags[$];
  logic m_sclk = 0, m_sdata = 0, m_le = 0;
  logic m_ce = 0, m_busy = 0, m_ready = 0, m_seq = 0, m_l1 = 0, m_l2 = 0;
  bit   started = 0;
  int   pcyc = 0;

  task automatic push_word(input logic [W-1:0] w, input int tag);
    for (int b = W - 1; b >= 0; b--) begin
      for (int k = 0; k < H; k++) mq.push_back({1'b0, w[b], 1'b0});
      for (int k = 0; k < H; k++) mq.push_back({1'b1, w[b], 1'b0});
    end
    for (int k = 0; k < LH; k++)    mq.push_back(3'b001);
    for (int k = 0; k < 2 * H; k++) mq.push_back(3'b000);
    exp_words.push_back(w);
    exp_tags.push_back(tag);
  endtask

  always @(posedge clk) begin
    logic [2:0] cur;
    started = 1;
    pcyc++;
    if (rst) begin
      mq.delete(); exp_words.delete(); exp_tags.delete();
      {m_sclk, m_sdata, m_le} = 3'b000;
      m_ce = 0; m_busy = 0; m_ready = 0; m_seq = 0; m_l1 = 0; m_l2 = 0;
    end else begin
      if (!m_busy && start) begin
        push_word(ref_word, 2); push_word(fb_word, 2); push_word(init_word, 2);
        m_ce = 1; m_ready = 0; m_seq = 1;
      end else if (!m_busy && upd_req) begin
        push_word(upd_word, 10);
      end
      if (mq.size() > 0) begin
        cur = mq.pop_front();
        m_busy = 1;
      end else begin
        cur = 3'b000;
        if (m_busy && m_seq) begin m_ready = 1; m_seq = 0; end
        m_busy = 0;
      end
      {m_sclk, m_sdata, m_le} = cur;
      m_l2 = m_l1;
      m_l1 = lock_in;
    end
    if (pcyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- per-cycle compare and word reassembly ----------------
  logic p_sclk = 0, p_le = 0;
  logic [W-1:0] acc = '0;
  int nbits = 0, ncyc = 0, last_rise = -1, gap_cnt = 0;
  bit gap_on = 0;

  always @(negedge clk) begin
    if (started) begin
      ncyc++;
      chk(m_busy ? "R3" : "R12", "sclk", sclk, m_sclk);
      chk(m_busy ? "R3" : "R12", "sdata", sdata, m_sdata);
      chk("R4", "le", le, m_le);
      chk("R2", "ce", ce, m_ce);
      chk("R7", "busy", busy, m_busy);
      chk("R9", "ready", ready, m_ready);
      chk("R11", "lock_flag", lock_flag, m_l2);

      if (gap_on) gap_cnt++;
      if (sclk && !p_sclk) begin
        acc = {acc[W-2:0], sdata};
        nbits++;
        if (last_rise >= 0) begin
          checks++;
          if ((ncyc - last_rise) * CLKNS < 50) begin
            errors++;
            $display("FAIL R6 sclk rise spacing actual=%0d ns expected>=50 ns",
                     (ncyc - last_rise) * CLKNS);
          end
        end
        last_rise = ncyc;
        if (gap_on) begin
          chk("R5", "cycles from le fall to next rise", gap_cnt, 3 * H);
          gap_on = 0;
        end
      end
      if (!le && p_le) begin gap_on = 1; gap_cnt = 0; end
      if (!busy) begin gap_on = 0; last_rise = -1; end
      if (le && !p_le) begin
        chk("R3", "bits per word", nbits, W);
        if (exp_words.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected word actual=%06h expected=none", acc);
        end else begin
          int tg;
          logic [W-1:0] ew;
          ew = exp_words.pop_front();
          tg = exp_tags.pop_front();
          chk(tg == 2 ? "R2" : "R10", "latched word", acc, ew);
        end
        nbits = 0;
      end
      p_sclk = sclk;
      p_le   = le;
    end
  end

  // lock-detect stimulus
  initial begin
    forever begin
      @(negedge clk);
      lock_in = ((ncyc % 37) < 11) ^ ((ncyc % 101) > 90);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic pulse(input logic s, input logic u, input logic [W-1:0] w);
    @(negedge clk);
    start = s; upd_req = u; upd_word = w;
    @(negedge clk);
    start = 0; upd_req = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "outputs in reset",
        {sclk, sdata, le, ce, busy, ready, lock_flag}, 7'b0);
    rst = 0;
    @(negedge clk);
    chk("R1", "outputs after reset", {sclk, sdata, le, ce, busy, ready}, 6'b0);

    ref_word = 24'h3C0011; fb_word = 24'h8F2E05; init_word = 24'h5A5A5F;
    pulse(1, 0, '0);
    chk("R2", "ce raised at start", ce, 1);
    chk("R7", "busy raised at start", busy, 1);
    repeat (200) @(negedge clk);
    pulse(0, 1, 24'h123456);           // R8: ignored while busy
    repeat (300) @(negedge clk);
    pulse(1, 0, '0);                    // R8: ignored while busy
    wait_idle();
    chk("R9", "ready after power-up", ready, 1);

    pulse(0, 1, 24'hFFFFFF);
    repeat (50) @(negedge clk);
    pulse(0, 1, 24'h0F0F0F);           // R8: ignored
    wait_idle();
    chk("R9", "ready kept by update", ready, 1);
    pulse(0, 1, 24'h000001); wait_idle();
    pulse(0, 1, 24'h800000); wait_idle();
    pulse(0, 1, 24'hAAAAAA); wait_idle();

    ref_word = 24'h000102; fb_word = 24'hFEDCBA; init_word = 24'h7FFFFE;
    pulse(1, 1, 24'h999999);           // R10: start wins
    chk("R9", "ready cleared by new start", ready, 0);
    wait_idle();
    chk("R9", "ready after second sequence", ready, 1);
    @(negedge clk);
    chk("R12", "idle lines", {sclk, sdata, le}, 3'b000);

    repeat (10) @(negedge clk);
    chk("R8", "no outstanding words", exp_words.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule